// File: doc/BRIEF.md
# DRAM Pattern-Register Read-Calibration Sequencer

This block sits on the controller side of a DDR3-style memory interface. It drives the command, bank-address and address buses through the short command sequence that read-timing calibration needs. First it closes all banks. Then it switches the memory into its predefined-pattern read mode and issues fixed-order burst-of-8 reads over and over. Data-capture logic elsewhere tunes its sampling point and signals success on `cap_ok_i`. The block then leaves pattern mode and reports completion.

Every timing wait is a runtime input: row precharge, mode-register command spacing, mode-register update delay, the post-pattern-read delay, additive latency and CAS latency. One down-counter enforces each wait. Where two waits apply to the same gap, the counter is loaded with the larger of the two. `rd_exp_o` marks the clock in which each read's data is due, for the capture logic. While pattern mode is active, a write request on `wr_req_i` is refused and flagged on `wr_blk_o`. An iteration limit stops the loop if capture never succeeds, and `err_o` is raised in that case.

Command codes on `cmd_o` are: 0 = NOP, 1 = precharge all, 2 = mode-register set, 3 = read. In this brief, "W after X" means that the later command appears on the bus W clocks after the cycle in which X was on the bus. A wait value of 0 is treated as 1.

Top module: `mpr_cal_seq`

## Requirements
- R1: While reset is active and after it is released with no start request, `cmd_o` is NOP, `ba_o` and `addr_o` are zero, and `rd_exp_o`, `mpr_mode_o`, `wr_blk_o`, `done_o` and `err_o` are all low.
- R2: A start request sampled in cycle s puts precharge-all (code 1) on the bus in cycle s+1, with `addr_o` bit 10 set, all other address bits zero and `ba_o` zero.
- R3: The pattern-mode entry command is a mode-register set (code 2) with `ba_o` = 3 and `addr_o` = 0x0004 (bit 2 set). It is issued max(t_rp,1) after the precharge.
- R4: The first read (code 3) is issued max(t_mrd,t_mod,1) after the entry command. Every read drives `ba_o` = 0 and `addr_o` = 0x1000: bit 12 is set and bits 2:0 are zero.
- R5: Successive reads are exactly 4 clocks apart. `cap_ok_i` is sampled in the third cycle after each read. If it is high there, no further read is issued.
- R6: If `cap_ok_i` is still low at the sample point after read number max(`max_iter_i`,1), reading stops. `err_o` is then high for as long as `done_o` is high. `err_o` stays low on a successful run.
- R7: The exit command is a mode-register set (code 2) with `ba_o` = 3 and `addr_o` = 0. It is issued 4 + max(AL+CL+t_mprr,1) after the last read.
- R8: `done_o` rises max(t_mrd,t_mod,1) after the exit command and stays high until the next start request.
- R9: `rd_exp_o` is high for exactly one cycle, AL+CL cycles after each read command (CL of at least 1).
- R10: `mpr_mode_o` is high from the cycle after the entry command through the cycle of the exit command. In every cycle, `wr_blk_o` equals `wr_req_i` AND `mpr_mode_o`.
- R11: In every cycle that carries none of the commands above, `cmd_o` is NOP and `ba_o` and `addr_o` are zero.
- R12: A start request while `done_o` is high clears `done_o` and `err_o` and begins a new sequence with the timing of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a calibration sequence when idle or done |
| t_rp_i | input | TW | Precharge-to-command wait, clocks |
| t_mrd_i | input | TW | Mode-register command spacing, clocks |
| t_mod_i | input | TW | Mode-register update delay, clocks |
| t_mprr_i | input | TW | Wait after the last pattern burst, clocks |
| al_i | input | ALW | Additive latency |
| cl_i | input | CLW | CAS latency |
| max_iter_i | input | ITW | Maximum number of calibration reads |
| cap_ok_i | input | 1 | Capture logic reports optimal sampling |
| wr_req_i | input | 1 | Write request from normal traffic |
| cmd_o | output | 2 | Command code |
| ba_o | output | BW | Bank address |
| addr_o | output | AW | Address bus |
| rd_exp_o | output | 1 | Read data due this cycle |
| mpr_mode_o | output | 1 | Memory is in pattern-read mode |
| wr_blk_o | output | 1 | Write request refused |
| done_o | output | 1 | Sequence complete |
| err_o | output | 1 | Iteration limit reached without success |

## Verification
All commands come from registered state, so each bus value is due in the cycle given by R2 to R8. These cycles are counted from the cycle in which the start request is sampled. The bench computes the whole expected trace from the timing inputs and compares the buses once per cycle, after inputs settle and half a clock before the next edge. `rd_exp_o` is checked against read cycle plus AL+CL. `wr_blk_o` follows `wr_req_i` in the same cycle, so the bench toggles the request every cycle. The capture-ready cycle is swept across read sample points to cover success, late success and the iteration limit.

// File: rtl/mpr_cal_pkg.sv
package mpr_cal_pkg;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_PALL = 2'd1,
    CMD_MRS  = 2'd2,
    CMD_READ = 2'd3
  } cmd_e;

  typedef enum logic [3:0] {
    S_IDLE, S_PALL, S_WRP, S_MRS_ON, S_WON, S_READ,
    S_WRD, S_WTAIL, S_MRS_OFF, S_WOFF, S_DONE
  } state_e;

  localparam int          RD_GAP     = 4;   // one BL8 burst on the bus
  localparam logic [2:0]  MR_SEL     = 3'd3;
  localparam int          PAT_EN_BIT = 2;
  localparam int          AP_BIT     = 10;
  localparam int          BL_BIT     = 12;

endpackage

// File: rtl/mpr_wait_cnt.sv
module mpr_wait_cnt #(
  parameter int CW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic [CW-1:0] cnt_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_o <= '0;
    else if (load_i)         cnt_o <= val_i;
    else if (cnt_o != '0)    cnt_o <= cnt_o - CW'(1);
  end

endmodule

// File: rtl/mpr_rd_strobe.sv
module mpr_rd_strobe #(
  parameter int RLW    = 5,
  parameter int RL_MAX = 22
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           rd_issue_i,
  input  logic [RLW-1:0] rl_i,
  output logic           rd_exp_o
);

  logic [RL_MAX:1] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[RL_MAX-1:1], rd_issue_i};
  end

  // select the tap matching the current latency
  logic [RL_MAX:1] tap_hit;
  for (genvar k = 1; k <= RL_MAX; k++) begin : g_tap
    assign tap_hit[k] = sh_q[k] && (rl_i == RLW'(k));
  end

  assign rd_exp_o = |tap_hit;

endmodule

// File: rtl/mpr_cal_fsm.sv
module mpr_cal_fsm
  import mpr_cal_pkg::*;
#(
  parameter int TW  = 8,
  parameter int CW  = 10,
  parameter int ITW = 6,
  parameter int AW  = 16,
  parameter int BW  = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           cap_ok_i,
  input  logic [ITW-1:0] max_iter_i,
  input  logic [TW-1:0]  w_rp_i,
  input  logic [TW-1:0]  w_mod_i,
  input  logic [CW-1:0]  w_tail_i,
  input  logic [CW-1:0]  cnt_i,
  output logic           load_o,
  output logic [CW-1:0]  load_val_o,
  output logic [1:0]     cmd_o,
  output logic [BW-1:0]  ba_o,
  output logic [AW-1:0]  addr_o,
  output logic           rd_issue_o,
  output logic           mode_o,
  output logic           done_o,
  output logic           fail_o
);

  state_e         state_q, state_d;
  logic [ITW-1:0] rd_cnt_q;
  logic           fail_q;
  logic           wait_end, go, limit;

  assign wait_end = (cnt_i <= CW'(1));
  assign go       = (state_q == S_IDLE || state_q == S_DONE) && start_i;
  assign limit    = (rd_cnt_q >= max_iter_i);

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    load_val_o = '0;
    unique case (state_q)
      S_IDLE, S_DONE: if (start_i) state_d = S_PALL;
      S_PALL: begin
        if (w_rp_i > TW'(1)) begin
          load_o = 1'b1; load_val_o = CW'(w_rp_i) - CW'(1); state_d = S_WRP;
        end else state_d = S_MRS_ON;
      end
      S_WRP: if (wait_end) state_d = S_MRS_ON;
      S_MRS_ON: begin
        if (w_mod_i > TW'(1)) begin
          load_o = 1'b1; load_val_o = CW'(w_mod_i) - CW'(1); state_d = S_WON;
        end else state_d = S_READ;
      end
      S_WON: if (wait_end) state_d = S_READ;
      S_READ: begin
        load_o = 1'b1; load_val_o = CW'(RD_GAP - 1); state_d = S_WRD;
      end
      S_WRD: begin
        if (wait_end) begin
          if (cap_ok_i || limit) begin
            load_o = 1'b1; load_val_o = w_tail_i; state_d = S_WTAIL;
          end else state_d = S_READ;
        end
      end
      S_WTAIL: if (wait_end) state_d = S_MRS_OFF;
      S_MRS_OFF: begin
        if (w_mod_i > TW'(1)) begin
          load_o = 1'b1; load_val_o = CW'(w_mod_i) - CW'(1); state_d = S_WOFF;
        end else state_d = S_DONE;
      end
      S_WOFF: if (wait_end) state_d = S_DONE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      rd_cnt_q <= '0;
      fail_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (go) begin
        rd_cnt_q <= '0;
        fail_q   <= 1'b0;
      end else begin
        if (state_q == S_READ) rd_cnt_q <= rd_cnt_q + ITW'(1);
        if (state_q == S_WRD && wait_end && !cap_ok_i && limit) fail_q <= 1'b1;
      end
    end
  end

  always_comb begin
    cmd_o  = CMD_NOP;
    ba_o   = '0;
    addr_o = '0;
    unique case (state_q)
      S_PALL:    begin cmd_o = CMD_PALL; addr_o[AP_BIT] = 1'b1; end
      S_MRS_ON:  begin cmd_o = CMD_MRS; ba_o = BW'(MR_SEL); addr_o[PAT_EN_BIT] = 1'b1; end
      S_READ:    begin cmd_o = CMD_READ; addr_o[BL_BIT] = 1'b1; end
      S_MRS_OFF: begin cmd_o = CMD_MRS; ba_o = BW'(MR_SEL); end
      default:   ;
    endcase
  end

  assign rd_issue_o = (state_q == S_READ);
  assign mode_o     = (state_q == S_WON) || (state_q == S_READ) || (state_q == S_WRD) ||
                      (state_q == S_WTAIL) || (state_q == S_MRS_OFF);
  assign done_o     = (state_q == S_DONE);
  assign fail_o     = fail_q;

endmodule

// File: rtl/mpr_cal_seq.sv
module mpr_cal_seq #(
  parameter int TW  = 8,
  parameter int ALW = 3,
  parameter int CLW = 4,
  parameter int ITW = 6,
  parameter int AW  = 16,
  parameter int BW  = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [TW-1:0]  t_rp_i,
  input  logic [TW-1:0]  t_mrd_i,
  input  logic [TW-1:0]  t_mod_i,
  input  logic [TW-1:0]  t_mprr_i,
  input  logic [ALW-1:0] al_i,
  input  logic [CLW-1:0] cl_i,
  input  logic [ITW-1:0] max_iter_i,
  input  logic           cap_ok_i,
  input  logic           wr_req_i,
  output logic [1:0]     cmd_o,
  output logic [BW-1:0]  ba_o,
  output logic [AW-1:0]  addr_o,
  output logic           rd_exp_o,
  output logic           mpr_mode_o,
  output logic           wr_blk_o,
  output logic           done_o,
  output logic           err_o
);

  localparam int RLW    = ((ALW > CLW) ? ALW : CLW) + 1;
  localparam int RL_MAX = (1 << ALW) - 1 + (1 << CLW) - 1;
  localparam int CW     = ((TW > RLW) ? TW : RLW) + 2;

  logic [TW-1:0]  w_rp, w_mod, mod_max;
  logic [RLW-1:0] rl;
  logic [CW-1:0]  tail_sum, w_tail, cnt, load_val;
  logic           load, rd_issue, fail;

  // zero waits collapse to one clock; paired waits take the larger
  assign mod_max  = (t_mrd_i > t_mod_i) ? t_mrd_i : t_mod_i;
  assign w_rp     = (t_rp_i  == '0) ? TW'(1) : t_rp_i;
  assign w_mod    = (mod_max == '0) ? TW'(1) : mod_max;
  assign rl       = RLW'(al_i) + RLW'(cl_i);
  assign tail_sum = CW'(rl) + CW'(t_mprr_i);
  assign w_tail   = (tail_sum == '0) ? CW'(1) : tail_sum;

  mpr_cal_fsm #(.TW(TW), .CW(CW), .ITW(ITW), .AW(AW), .BW(BW)) u_fsm (
    .clk_i, .rst_ni, .start_i, .cap_ok_i, .max_iter_i,
    .w_rp_i(w_rp), .w_mod_i(w_mod), .w_tail_i(w_tail), .cnt_i(cnt),
    .load_o(load), .load_val_o(load_val),
    .cmd_o, .ba_o, .addr_o, .rd_issue_o(rd_issue),
    .mode_o(mpr_mode_o), .done_o, .fail_o(fail)
  );

  mpr_wait_cnt #(.CW(CW)) u_cnt (
    .clk_i, .rst_ni, .load_i(load), .val_i(load_val), .cnt_o(cnt)
  );

  mpr_rd_strobe #(.RLW(RLW), .RL_MAX(RL_MAX)) u_strobe (
    .clk_i, .rst_ni, .rd_issue_i(rd_issue), .rl_i(rl), .rd_exp_o
  );

  assign wr_blk_o = wr_req_i && mpr_mode_o;
  assign err_o    = done_o && fail;

endmodule

// File: rtl/mpr_cal_seq_chk.sv
module mpr_cal_seq_chk
  import mpr_cal_pkg::*;
#(
  parameter int AW = 16,
  parameter int BW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          wr_req_i,
  input logic [1:0]    cmd_o,
  input logic [BW-1:0] ba_o,
  input logic [AW-1:0] addr_o,
  input logic          mpr_mode_o,
  input logic          wr_blk_o,
  input logic          done_o,
  input logic          err_o
);

  // R11
  nop_quiet_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o == CMD_NOP |-> ba_o == '0 && addr_o == '0);

  // R5
  read_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o == CMD_READ |-> $past(cmd_o) != CMD_READ && $past(cmd_o, 2) != CMD_READ &&
                          $past(cmd_o, 3) != CMD_READ);

  // R4
  read_in_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o == CMD_READ |-> mpr_mode_o && ba_o == '0 && addr_o == (AW'(1) << BL_BIT));

  // R10
  write_refused_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_i && mpr_mode_o |-> wr_blk_o);

  // R10
  write_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mpr_mode_o |-> !wr_blk_o);

  // R7
  mode_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mpr_mode_o) |-> $past(cmd_o) == CMD_MRS && $past(ba_o) == BW'(MR_SEL));

  // R8
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o);

  // R6
  err_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);

endmodule

bind mpr_cal_seq mpr_cal_seq_chk #(.AW(AW), .BW(BW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .wr_req_i(wr_req_i),
  .cmd_o(cmd_o), .ba_o(ba_o), .addr_o(addr_o), .mpr_mode_o(mpr_mode_o),
  .wr_blk_o(wr_blk_o), .done_o(done_o), .err_o(err_o)
);

// File: tb/mpr_cal_seq_tb.sv
module mpr_cal_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 8, ALW = 3, CLW = 4, ITW = 6, AW = 16, BW = 3;

  logic clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0, cap_ok_i = 1'b0, wr_req_i = 1'b0;
  logic [TW-1:0] t_rp_i = '0, t_mrd_i = '0, t_mod_i = '0, t_mprr_i = '0;
  logic [ALW-1:0] al_i = '0;
  logic [CLW-1:0] cl_i = '0;
  logic [ITW-1:0] max_iter_i = '0;
  logic [1:0] cmd_o;
  logic [BW-1:0] ba_o;
  logic [AW-1:0] addr_o;
  logic rd_exp_o, mpr_mode_o, wr_blk_o, done_o, err_o;

  mpr_cal_seq #(.TW(TW), .ALW(ALW), .CLW(CLW), .ITW(ITW), .AW(AW), .BW(BW)) u_dut (
    .clk_i(clk), .rst_ni, .start_i, .t_rp_i, .t_mrd_i, .t_mod_i, .t_mprr_i,
    .al_i, .cl_i, .max_iter_i, .cap_ok_i, .wr_req_i,
    .cmd_o, .ba_o, .addr_o, .rd_exp_o, .mpr_mode_o, .wr_blk_o, .done_o, .err_o
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0, n_err = 0;
  bit fin = 0;
  int prev_done = 0, prev_err = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic run_case(input int trp, input int tmrd, input int tmod, input int tmprr,
                          input int al, input int cl, input int mi, input int okc);
    int wm, t_mrs1, t_rd1, m, n, fail, t_last, rl, v, t_mrs2, t_done;
    wm     = (tmrd > tmod) ? tmrd : tmod;
    if (wm < 1) wm = 1;
    t_mrs1 = 1 + ((trp < 1) ? 1 : trp);
    t_rd1  = t_mrs1 + wm;
    m      = (mi < 1) ? 1 : mi;
    n = m; fail = 1;
    for (int k = 1; k <= m; k++) begin
      if (t_rd1 + 4 * (k - 1) + 3 >= okc) begin n = k; fail = 0; break; end
    end
    t_last = t_rd1 + 4 * (n - 1);
    rl     = al + cl;
    v      = (rl + tmprr < 1) ? 1 : rl + tmprr;
    t_mrs2 = t_last + 4 + v;
    t_done = t_mrs2 + wm;
    for (int r = 0; r <= t_done + 1; r++) begin
      int e_cmd, e_ba, e_addr, e_mode, e_exp, e_done, e_err, rr;
      bit is_rd;
      string tag;
      @(negedge clk);
      if (r == 0) begin
        t_rp_i = TW'(trp); t_mrd_i = TW'(tmrd); t_mod_i = TW'(tmod); t_mprr_i = TW'(tmprr);
        al_i = ALW'(al); cl_i = CLW'(cl); max_iter_i = ITW'(mi);
      end
      start_i  = (r == 0);
      cap_ok_i = (r >= okc);
      wr_req_i = r[0];
      #1;
      is_rd = (r >= t_rd1) && (r <= t_last) && ((r - t_rd1) % 4 == 0);
      e_cmd = 0; e_ba = 0; e_addr = 0; tag = "R11";
      if (r == 1)           begin e_cmd = 1; e_addr = 1 << 10; tag = "R2"; end
      else if (r == t_mrs1) begin e_cmd = 2; e_ba = 3; e_addr = 4; tag = "R3"; end
      else if (is_rd)       begin e_cmd = 3; e_addr = 16'h1000; tag = (r == t_rd1) ? "R4" : "R5"; end
      else if (r == t_mrs2) begin e_cmd = 2; e_ba = 3; tag = "R7"; end
      rr    = r - rl;
      e_exp = (rr >= t_rd1 && rr <= t_last && ((rr - t_rd1) % 4 == 0)) ? 1 : 0;
      e_mode = (r > t_mrs1 && r <= t_mrs2) ? 1 : 0;
      e_done = (r == 0) ? prev_done : (r >= t_done ? 1 : 0);
      e_err  = (r == 0) ? prev_err : ((r >= t_done && fail == 1) ? 1 : 0);
      chk(tag, "cmd", int'(cmd_o), e_cmd);
      chk(tag, "ba", int'(ba_o), e_ba);
      chk(tag, "addr", int'(addr_o), e_addr);
      chk("R9", "rd_exp", int'(rd_exp_o), e_exp);
      chk("R10", "mode", int'(mpr_mode_o), e_mode);
      chk("R10", "wr_blk", int'(wr_blk_o), e_mode & int'(r[0]));
      chk((r == 0) ? "R12" : "R8", "done", int'(done_o), e_done);
      chk("R6", "err", int'(err_o), e_err);
    end
    start_i = 1'b0;
    prev_done = 1;
    prev_err  = fail;
  endtask

  initial begin
    int trp_v[3]  = '{0, 1, 3};
    int mrd_v[3]  = '{1, 4, 0};
    int mod_v[3]  = '{4, 2, 0};
    int mprr_v[2] = '{0, 2};
    int al_v[2]   = '{0, 2};
    int cl_v[2]   = '{1, 5};
    int ok_v[3]   = '{0, 14, 9999};
    int mi_v[2]   = '{0, 3};
    // R1: reset state
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "cmd", int'(cmd_o), 0);
    chk("R1", "addr", int'(addr_o), 0);
    chk("R1", "done", int'(done_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk("R1", "cmd", int'(cmd_o), 0);
    chk("R1", "ba", int'(ba_o), 0);
    chk("R1", "mode", int'(mpr_mode_o), 0);
    chk("R1", "rd_exp", int'(rd_exp_o), 0);
    chk("R1", "err", int'(err_o), 0);
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        for (int c = 0; c < 2; c++)
          for (int d = 0; d < 2; d++)
            for (int e = 0; e < 2; e++)
              for (int f = 0; f < 3; f++)
                for (int g = 0; g < 2; g++)
                  run_case(trp_v[a], mrd_v[b], mod_v[b], mprr_v[c], al_v[d], cl_v[e],
                           mi_v[g], ok_v[f]);
    if (!fin) begin
      fin = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!fin) begin
      fin = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule